// File: doc/BRIEF.md
# DDR4 Mode Register Load Sequencer

This block walks a registered DIMM through the mode-register programming step of DDR4 power-up. A single start pulse launches the walk. The block captures a mask of populated ranks and then steps through the seven mode registers in a fixed order. For each register it visits every populated rank in ascending order. Each rank receives a pair of MRS commands. The first targets the A side of the register buffer. The second targets the B side, with selected address and bank bits inverted. On odd ranks the address is mirrored before either command goes out.

The seven 18-bit register payloads arrive on one flat input and are read as each command is issued. MR number n sits at bits n*18 and up. The bank group and bank address follow from the register number. Every command is followed by a fixed idle gap, during which the interface is held in deselect. When the gap after the last command ends, the block raises a one-cycle done flag and returns to idle.

Top module: `mrs_load_seq`

## Requirements
- R1: Registers are issued in the order MR3, MR6, MR5, MR4, MR2, MR1, MR0. Before mirroring and inversion, a command for MR n carries address = bits [n*18+17 : n*18] of `mr_data_i`, `ba_o` = n[1:0] and `bg_o` = {0, n[2]}.
- R2: The register index forms the outer loop and the rank the inner loop. Populated ranks are visited in ascending order, and ranks whose mask bit is clear take no cycles.
- R3: Each visited rank receives two consecutive commands: first the A side, then the B side.
- R4: On odd ranks both commands are mirrored. The mirror swaps address bits 3↔4, 5↔6, 7↔8 and 11↔13, `ba_o` bits 0↔1 and `bg_o` bits 0↔1.
- R5: The B-side command equals the A-side command XOR a fixed pattern. The pattern flips address bits 3–9, 11, 13 and 17, both `ba_o` bits and both `bg_o` bits. Address bits 0–2, 10, 12 and 14–16 are unchanged.
- R6: During a command cycle, `cmd_valid_o`=1, exactly one `cs_n_o` bit (the rank) is 0, `act_n_o`=1 and `ras_n_o`/`cas_n_o`/`we_n_o`=0. In every other cycle, `cs_n_o` is all ones and `ras_n_o`/`cas_n_o`/`we_n_o`=1.
- R7: The first command appears in the cycle after the clock edge that samples `start_i`. Every command is followed by IDLE_CYC (default 8) idle cycles, so commands sit IDLE_CYC+1 cycles apart.
- R8: `done_o` is high for exactly one cycle, the one following the final idle gap. With an all-zero mask, it is high in the cycle after `start_i` is sampled.
- R9: A start pulse while a sequence is running is ignored.
- R10: The rank mask is captured at start, and changes to `rank_mask_i` during a run have no effect on that run.
- R11: After reset, `cmd_valid_o`=0, `done_o`=0 and `cs_n_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| rank_mask_i | input | NUM_RANKS | Populated-rank mask, bit r = rank r |
| mr_data_i | input | 7*18 | Register payloads, MR n at bits n*18 and up |
| cmd_valid_o | output | 1 | High in a command cycle |
| cs_n_o | output | NUM_RANKS | Per-rank chip select, active low |
| act_n_o | output | 1 | Activate strobe, held high |
| ras_n_o | output | 1 | Row strobe, low during command |
| cas_n_o | output | 1 | Column strobe, low during command |
| we_n_o | output | 1 | Write enable, low during command |
| addr_o | output | 18 | Command address |
| ba_o | output | 2 | Bank address |
| bg_o | output | 2 | Bank group |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every mask of a four-rank configuration and checks every cycle of each run against a model built from the register order and the bit lists.

- A sparse or empty mask catches a design that spends cycles on absent ranks, or one that never reports done.
- Registers chosen so that swapped bit pairs differ catch a mirror that is missing, lands on even ranks, or misses a pair.
- B-side fields catch an inversion pattern with the wrong bits.
- Mid-run start pulses and mask changes catch a design that restarts the walk or reads the live mask.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;
  localparam int MR_COUNT = 7;
  localparam int ADDR_W   = 18;
  localparam int POS_W    = 3;
  localparam logic [ADDR_W-1:0] B_ADDR_FLIP = 18'h22BF8;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_GAP} seq_state_e;

  // Position in the walk -> mode register number: 3,6,5,4,2,1,0
  function automatic logic [2:0] pos_to_mr(input logic [POS_W-1:0] pos);
    if (pos == 3'd0)      return 3'd3;
    else if (pos <= 3'd3) return 3'(7 - pos);
    else                  return 3'(6 - pos);
  endfunction
endpackage

// File: rtl/mrs_rank_pick.sv
module mrs_rank_pick #(
  parameter int NUM_RANKS = 4,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic [NUM_RANKS-1:0] mask_i,
  input  logic [RANK_W:0]      from_i,
  output logic                 found_o,
  output logic [RANK_W-1:0]    idx_o
);
  // Lowest set mask bit at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (mask_i[i] && ((RANK_W+1)'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = RANK_W'(i);
      end
    end
  end
endmodule

// File: rtl/mrs_addr_xform.sv
module mrs_addr_xform
  import mrs_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        ba_i,
  input  logic [1:0]        bg_i,
  input  logic              mirror_i,
  input  logic              invert_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        ba_o,
  output logic [1:0]        bg_o
);
  logic [ADDR_W-1:0] m_addr;
  logic [1:0]        m_ba, m_bg;

  always_comb begin
    m_addr = addr_i;
    m_ba   = ba_i;
    m_bg   = bg_i;
    if (mirror_i) begin
      m_addr[3]  = addr_i[4];  m_addr[4]  = addr_i[3];
      m_addr[5]  = addr_i[6];  m_addr[6]  = addr_i[5];
      m_addr[7]  = addr_i[8];  m_addr[8]  = addr_i[7];
      m_addr[11] = addr_i[13]; m_addr[13] = addr_i[11];
      m_ba = {ba_i[0], ba_i[1]};
      m_bg = {bg_i[0], bg_i[1]};
    end
    addr_o = invert_i ? (m_addr ^ B_ADDR_FLIP) : m_addr;
    ba_o   = invert_i ? ~m_ba : m_ba;
    bg_o   = invert_i ? ~m_bg : m_bg;
  end
endmodule

// File: rtl/mrs_gap_timer.sv
module mrs_gap_timer #(
  parameter int IDLE_CYC = 8,
  localparam int CNT_W = $clog2(IDLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = run_i ? cnt_q + 1'b1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = run_i && (cnt_q == CNT_W'(IDLE_CYC - 1));
endmodule

// File: rtl/mrs_load_seq.sv
module mrs_load_seq
  import mrs_seq_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int IDLE_CYC  = 8,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [NUM_RANKS-1:0]         rank_mask_i,
  input  logic [MR_COUNT*ADDR_W-1:0]   mr_data_i,
  output logic                         cmd_valid_o,
  output logic [NUM_RANKS-1:0]         cs_n_o,
  output logic                         act_n_o,
  output logic                         ras_n_o,
  output logic                         cas_n_o,
  output logic                         we_n_o,
  output logic [ADDR_W-1:0]            addr_o,
  output logic [1:0]                   ba_o,
  output logic [1:0]                   bg_o,
  output logic                         done_o
);
  seq_state_e           state_q, state_d;
  logic [POS_W-1:0]     pos_q, pos_d;
  logic [RANK_W-1:0]    rank_q, rank_d, first_q, first_d;
  logic                 side_q, side_d;
  logic [NUM_RANKS-1:0] mask_q, mask_d;
  logic                 done_q, done_d;
  logic                 load_en;

  logic              st_found, nx_found, gap_last;
  logic [RANK_W-1:0] st_idx, nx_idx;
  logic [2:0]        mr_num;

  mrs_rank_pick #(.NUM_RANKS(NUM_RANKS)) start_pick_i (
    .mask_i(rank_mask_i), .from_i('0), .found_o(st_found), .idx_o(st_idx));

  mrs_rank_pick #(.NUM_RANKS(NUM_RANKS)) next_pick_i (
    .mask_i(mask_q), .from_i({1'b0, rank_q} + 1'b1),
    .found_o(nx_found), .idx_o(nx_idx));

  mrs_gap_timer #(.IDLE_CYC(IDLE_CYC)) gap_i (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_GAP), .last_o(gap_last));

  // Next-state logic
  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    rank_d  = rank_q;
    first_d = first_q;
    side_d  = side_q;
    mask_d  = mask_q;
    done_d  = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_en = 1'b1;
        mask_d  = rank_mask_i;
        pos_d   = '0;
        side_d  = 1'b0;
        first_d = st_idx;
        rank_d  = st_idx;
        if (st_found) state_d = ST_CMD;
        else          done_d  = 1'b1;
      end
      ST_CMD: state_d = ST_GAP;
      ST_GAP: if (gap_last) begin
        state_d = ST_CMD;
        if (!side_q) begin
          side_d = 1'b1;
        end else begin
          side_d = 1'b0;
          if (nx_found) begin
            rank_d = nx_idx;
          end else if (pos_q == POS_W'(MR_COUNT - 1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            pos_d  = pos_q + 1'b1;
            rank_d = first_q;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      rank_q  <= '0;
      side_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      rank_q  <= rank_d;
      side_q  <= side_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      first_q <= '0;
    end else if (load_en) begin
      mask_q  <= mask_d;
      first_q <= first_d;
    end
  end

  // Command output
  assign mr_num      = pos_to_mr(pos_q);
  assign cmd_valid_o = (state_q == ST_CMD);
  assign act_n_o     = 1'b1;
  assign ras_n_o     = ~cmd_valid_o;
  assign cas_n_o     = ~cmd_valid_o;
  assign we_n_o      = ~cmd_valid_o;
  assign done_o      = done_q;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_cs
    assign cs_n_o[r] = ~(cmd_valid_o && (rank_q == RANK_W'(r)));
  end

  mrs_addr_xform xform_i (
    .addr_i  (mr_data_i[int'(mr_num)*ADDR_W +: ADDR_W]),
    .ba_i    (mr_num[1:0]),
    .bg_i    ({1'b0, mr_num[2]}),
    .mirror_i(rank_q[0]),
    .invert_i(side_q),
    .addr_o  (addr_o),
    .ba_o    (ba_o),
    .bg_o    (bg_o));
endmodule

// File: rtl/mrs_load_seq_chk.sv
module mrs_load_seq_chk #(
  parameter int NUM_RANKS = 4,
  parameter int IDLE_CYC  = 8,
  localparam int CNT_W = $clog2(IDLE_CYC + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid_o,
  input logic [NUM_RANKS-1:0] cs_n_o,
  input logic                 act_n_o,
  input logic                 ras_n_o,
  input logic                 cas_n_o,
  input logic                 we_n_o,
  input logic                 done_o
);
  logic [CNT_W-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              since_q <= CNT_W'(IDLE_CYC);
    else if (cmd_valid_o)                    since_q <= '0;
    else if (since_q < CNT_W'(IDLE_CYC))     since_q <= since_q + 1'b1;
  end

  // R6
  cmd_cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> ($countones(~cs_n_o) == 1 && act_n_o && !ras_n_o && !cas_n_o && !we_n_o));
  // R6
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_o |-> (&cs_n_o && ras_n_o && cas_n_o && we_n_o));
  // R7
  gap_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> since_q >= CNT_W'(IDLE_CYC));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  done_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmd_valid_o);
endmodule

bind mrs_load_seq mrs_load_seq_chk #(.NUM_RANKS(NUM_RANKS), .IDLE_CYC(IDLE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid_o(cmd_valid_o), .cs_n_o(cs_n_o),
  .act_n_o(act_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
  .done_o(done_o));

// File: tb/mrs_load_seq_tb_top.sv
`timescale 1ns/1ps
module mrs_load_seq_tb_top;
  localparam int NR  = 4;
  localparam int GAP = 8;

  logic          clk, rst_n, start_i;
  logic [NR-1:0] rank_mask_i;
  logic [125:0]  mr_data_i;
  logic          cmd_valid_o, act_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [NR-1:0] cs_n_o;
  logic [17:0]   addr_o;
  logic [1:0]    ba_o, bg_o;

  int checks = 0;
  int errors = 0;

  mrs_load_seq #(.NUM_RANKS(NR), .IDLE_CYC(GAP)) dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int walk_mr(input int pos);
    int t[7] = '{3, 6, 5, 4, 2, 1, 0};
    return t[pos];
  endfunction

  task automatic set_mr(input int seed);
    for (int n = 0; n < 7; n++)
      mr_data_i[n*18 +: 18] = 18'(((seed + 1) * 40503) ^ ((n + 1) * 127957) ^ (n * 4681));
  endtask

  // One full run; busy_at: sample index at which to pulse start again (0 = none)
  task automatic run_seq(input logic [NR-1:0] mask, input int busy_at,
                         input bit alt_en, input logic [NR-1:0] alt_mask);
    int pres[NR];
    int np = 0;
    int n;
    for (int r = 0; r < NR; r++) if (mask[r]) begin pres[np] = r; np++; end
    n = 14 * np;
    @(negedge clk);
    rank_mask_i = mask;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 1; t <= 9 * n + 3; t++) begin
      bit ev, ed;
      ev = ((t - 1) % (GAP + 1) == 0) && ((t - 1) / (GAP + 1) < n);
      ed = (t == 1 + (GAP + 1) * n);
      chk(cmd_valid_o == ev, "R7 command timing", 64'(cmd_valid_o), 64'(ev));
      chk(done_o == ed, "R8 done pulse", 64'(done_o), 64'(ed));
      if (ev) begin
        int k, mr, rk, side;
        logic [17:0] ea;
        logic [1:0]  eba, ebg, tmp;
        logic [63:0] got, exp;
        k    = (t - 1) / (GAP + 1);
        mr   = walk_mr(k / (2 * np));
        rk   = pres[(k % (2 * np)) / 2];
        side = k % 2;
        ea  = mr_data_i[mr*18 +: 18];
        eba = 2'(mr & 3);
        ebg = {1'b0, 1'(mr >> 2)};
        if (rk % 2 == 1) begin
          logic [17:0] s;
          s = ea;
          ea[3] = s[4];   ea[4] = s[3];   ea[5] = s[6];  ea[6] = s[5];
          ea[7] = s[8];   ea[8] = s[7];   ea[11] = s[13]; ea[13] = s[11];
          tmp = eba; eba = {tmp[0], tmp[1]};
          tmp = ebg; ebg = {tmp[0], tmp[1]};
        end
        if (side == 1) begin
          for (int b = 3; b <= 9; b++) ea[b] = ~ea[b];
          ea[11] = ~ea[11]; ea[13] = ~ea[13]; ea[17] = ~ea[17];
          eba = ~eba; ebg = ~ebg;
        end
        got = {28'd0, cs_n_o, act_n_o, ras_n_o, cas_n_o, we_n_o, addr_o, ba_o, bg_o};
        exp = {28'd0, ~(NR'(1) << rk), 1'b1, 3'b000, ea, eba, ebg};
        chk(got == exp, $sformatf("R1 R2 R3 R4 R5 R6 mr%0d rank%0d side%0d", mr, rk, side), got, exp);
      end else begin
        chk(cs_n_o == '1 && ras_n_o && cas_n_o && we_n_o, "R6 idle deselect",
            64'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 64'({{NR{1'b1}}, 3'b111}));
      end
      if (alt_en && t == 3) rank_mask_i = alt_mask;   // R10
      start_i = (busy_at != 0 && t == busy_at);        // R9
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    rank_mask_i = '0;
    set_mr(0);
    repeat (3) @(negedge clk);
    // R11
    chk(!cmd_valid_o && !done_o && cs_n_o == '1, "R11 reset state",
        64'({cmd_valid_o, done_o, cs_n_o}), 64'({2'b00, {NR{1'b1}}}));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int m = 0; m < (1 << NR); m++) begin
      set_mr(m);
      run_seq(NR'(m), 0, 1'b0, '0);
    end
    set_mr(21);
    run_seq(4'b1111, 20, 1'b0, '0);    // R9 restart attempt mid-run
    set_mr(22);
    run_seq(4'b0110, 40, 1'b1, 4'b1001); // R9 and R10
    set_mr(23);
    run_seq(4'b1000, 0, 1'b1, 4'b0000);  // R10 mask cleared mid-run
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule